// File: doc/BRIEF.md
# Bridge Link Controller (Controller Side)

This block is the controller end of a point-to-point link to a peripheral bridge. Four active-low sideband pins and one shared 16-bit bus make up the link. The bridge asks for link mastership on a request pin, and the controller answers on a grant pin. Whichever end is master marks the start of a transfer with a command strobe. The other end, acting as slave, signals that it can take data on a ready pin. Command, address and data words all travel over the shared bus. When the controller is master, a transfer is one header beat followed by a programmable number of data beats. Each data beat advances only in a cycle where the bridge shows ready.

The controller is master by default. A host posts transfers through a valid/ready request port and supplies the data words through a take-strobe port. When the bridge requests the link, the controller finishes any transfer in progress, then grants the link and holds the grant until the request is withdrawn. While the bridge is master, the controller acts as slave. It captures the header word that arrives with the bridge's command strobe and offers it on a response port. At power-up, the command-strobe and ready pins also serve as a 2-bit clock-configuration strap, which the controller latches when power-good rises.

Top module: `bridge_link_ctrl`

## Requirements
- R1: While `rst` is high or `pgood` is low, the link logic is held in reset. In that state `cstb_n_o`, `mgnt_n_o` and `srdy_n_o` are high, and `lbus_oe`, `hreq_ready`, `hdat_take` and `rsp_valid` are low.
- R2: `strap_o[1]` takes the level of `cstb_n_i` and `strap_o[0]` the level of `srdy_n_i`, as sampled in the last cycle with `pgood` low. The value is loaded on the first clock with `pgood` high and then holds while `pgood` stays high. `rst` clears it to 0.
- R3: In the cycle after a request is accepted (`hreq_valid` and `hreq_ready` both high at a clock edge), `cstb_n_o` is low for exactly one cycle, with `lbus_oe` high and `lbus_o` equal to the request's `hreq_hdr`.
- R4: After the header beat, `hreq_len` data beats follow on `lbus_o`, taken from `hdat_data` in the order of the `hdat_take` strobes. A beat is accepted at a clock edge where `srdy_n_i` is low. While `srdy_n_i` is high, `lbus_o` holds its value.
- R5: `hreq_ready` is high only when the controller owns the link, no transfer is active, `srdy_n_i` is low and `mreq_n_i` is high. A request offered at any other time, including while the bridge is master, starts nothing.
- R6: The grant `mgnt_n_o` goes low only when no transfer is active and both `srdy_n_i` and `mreq_n_i` are low. It stays low while `mreq_n_i` stays low, and it returns high one cycle after `mreq_n_i` goes high. A request raised during a transfer is granted after that transfer's last beat.
- R7: The controller never drives the bus (`lbus_oe` low) while it grants the link. After the grant is withdrawn, there is one turnaround cycle with `hreq_ready` low before the controller can start again.
- R8: While the bridge is master, `srdy_n_o` is low unless a captured header is waiting. A low `cstb_n_i` captures `lbus_i` into `rsp_hdr` and raises `rsp_valid`. `rsp_valid` and `rsp_hdr` then hold, with `srdy_n_o` high, until `rsp_ready` is high at a clock edge.
- R9: A request with `hreq_len` of 0 produces only the header beat. `lbus_oe` falls in the following cycle and no data is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| pgood | input | 1 | Power-good; low holds the link in reset and samples the strap |
| mreq_n_i | input | 1 | Bridge request for link mastership, active low |
| mgnt_n_o | output | 1 | Grant of link mastership to the bridge, active low |
| cstb_n_i | input | 1 | Command strobe from the bridge when it is master; strap bit 1 |
| cstb_n_o | output | 1 | Command strobe driven when the controller is master |
| srdy_n_i | input | 1 | Slave-ready from the bridge; strap bit 0 |
| srdy_n_o | output | 1 | Slave-ready driven when the bridge is master |
| lbus_i | input | DW | Shared link bus, incoming value |
| lbus_o | output | DW | Shared link bus, outgoing value |
| lbus_oe | output | 1 | Output enable of the shared bus |
| hreq_valid | input | 1 | Host transfer request valid |
| hreq_ready | output | 1 | Host transfer request accepted |
| hreq_hdr | input | DW | Header word (command and address) |
| hreq_len | input | LW | Number of data beats |
| hdat_data | input | DW | Next data word from the host |
| hdat_take | output | 1 | Data word is consumed at this clock edge |
| rsp_valid | output | 1 | Captured bridge header available |
| rsp_ready | input | 1 | Host consumes the captured header |
| rsp_hdr | output | DW | Captured bridge header |
| strap_o | output | 2 | Latched clock-configuration strap |

## Verification
Assertions check several invariants on every cycle: the one-cycle command strobe, the held bus during stalls, grant persistence under a live request, a bus that is never driven while the link is granted, ready asserted only toward a granted bridge, a held strap, and a held response. Other properties need whole scenarios, so only the bench scenarios can show them. These include the order and values of the header and data words against the host's stream, the exact strap value captured at power-good, a grant that is deferred until a transfer's last beat, the turnaround cycle, and a request offered to a bridge-owned link that produces no beat.

// File: rtl/blink_pkg.sv
package blink_pkg;
  typedef enum logic [1:0] {X_IDLE, X_CMD, X_DATA} xfer_st_t;
  typedef enum logic [1:0] {O_CTRL, O_BR, O_TURN} own_t;
endpackage

// File: rtl/blink_strap.sv
module blink_strap #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pgood,
  input  logic [SW-1:0] pins,
  output logic [SW-1:0] strap
);
  logic [SW-1:0] samp_q;
  logic [SW-1:0] strap_q;
  logic          pg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q  <= '0;
      strap_q <= '0;
      pg_q    <= 1'b0;
    end else begin
      pg_q <= pgood;
      if (!pgood) samp_q <= pins;
      if (pgood && !pg_q) strap_q <= samp_q;
    end
  end

  assign strap = strap_q;

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pg_q && pgood) |=> $stable(strap_q));
endmodule

// File: rtl/blink_arb.sv
module blink_arb
  import blink_pkg::*;
(
  input  logic clk,
  input  logic lrst,
  input  logic mreq_n_i,
  input  logic srdy_n_i,
  input  logic xfer_idle,
  output own_t own,
  output own_t own_nxt,
  output logic mgnt_n_o
);
  own_t own_q, nxt;
  logic mgnt_q;
  logic grant_ok;

  assign grant_ok = xfer_idle && !srdy_n_i && !mreq_n_i;

  always_comb begin
    nxt = own_q;
    case (own_q)
      O_CTRL:  if (grant_ok) nxt = O_BR;
      O_BR:    if (mreq_n_i) nxt = O_TURN;
      O_TURN:  nxt = O_CTRL;
      default: nxt = O_CTRL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (lrst) begin
      own_q  <= O_CTRL;
      mgnt_q <= 1'b1;
    end else begin
      own_q  <= nxt;
      mgnt_q <= (nxt != O_BR);
    end
  end

  assign own      = own_q;
  assign own_nxt  = nxt;
  assign mgnt_n_o = mgnt_q;

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (lrst)
    (!mgnt_q && !mreq_n_i) |=> !mgnt_q);
  // R6
  grant_release_chk: assert property (@(posedge clk) disable iff (lrst)
    (!mgnt_q && mreq_n_i) |=> mgnt_q);
endmodule

// File: rtl/blink_xfer.sv
module blink_xfer
  import blink_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          lrst,
  input  logic          start,
  input  logic [DW-1:0] hdr,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] hdat_data,
  input  logic          srdy_n_i,
  input  logic          own_br,
  input  logic          own_br_nxt,
  input  logic          cstb_n_i,
  input  logic [DW-1:0] lbus_i,
  input  logic          rsp_ready,
  output logic          idle,
  output logic [DW-1:0] lbus_o,
  output logic          lbus_oe,
  output logic          cstb_n_o,
  output logic          hdat_take,
  output logic          srdy_n_o,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_hdr
);
  localparam logic [LW-1:0] ONE = LW'(1);

  xfer_st_t      st_q;
  logic [DW-1:0] bus_q;
  logic          oe_q;
  logic          cstb_q;
  logic [LW-1:0] rem_q;

  // master side: header beat then data beats paced by slave-ready
  always_ff @(posedge clk) begin
    if (lrst) begin
      st_q   <= X_IDLE;
      bus_q  <= '0;
      oe_q   <= 1'b0;
      cstb_q <= 1'b1;
      rem_q  <= '0;
    end else begin
      case (st_q)
        X_IDLE: if (start) begin
          bus_q  <= hdr;
          oe_q   <= 1'b1;
          cstb_q <= 1'b0;
          rem_q  <= len;
          st_q   <= X_CMD;
        end
        X_CMD: begin
          cstb_q <= 1'b1;
          if (rem_q == '0) begin
            oe_q <= 1'b0;
            st_q <= X_IDLE;
          end else begin
            bus_q <= hdat_data;
            st_q  <= X_DATA;
          end
        end
        X_DATA: if (!srdy_n_i) begin
          if (rem_q == ONE) begin
            oe_q  <= 1'b0;
            rem_q <= '0;
            st_q  <= X_IDLE;
          end else begin
            bus_q <= hdat_data;
            rem_q <= rem_q - ONE;
          end
        end
        default: st_q <= X_IDLE;
      endcase
    end
  end

  assign hdat_take = ((st_q == X_CMD) && (rem_q != '0)) ||
                     ((st_q == X_DATA) && !srdy_n_i && (rem_q != ONE));
  assign idle     = (st_q == X_IDLE);
  assign lbus_o   = bus_q;
  assign lbus_oe  = oe_q;
  assign cstb_n_o = cstb_q;

  // slave side: capture the bridge header, hold it until read
  logic pend_q, pend_nxt, srdy_q;
  logic [DW-1:0] rhdr_q;
  logic capture;

  assign capture = !srdy_q && !cstb_n_i;

  always_comb begin
    pend_nxt = pend_q;
    if (capture) pend_nxt = 1'b1;
    else if (pend_q && rsp_ready) pend_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (lrst) begin
      pend_q <= 1'b0;
      rhdr_q <= '0;
      srdy_q <= 1'b1;
    end else begin
      pend_q <= pend_nxt;
      if (capture) rhdr_q <= lbus_i;
      srdy_q <= !(own_br_nxt && !pend_nxt);
    end
  end

  assign srdy_n_o  = srdy_q;
  assign rsp_valid = pend_q;
  assign rsp_hdr   = rhdr_q;

  // R3
  cstb_one_beat_chk: assert property (@(posedge clk) disable iff (lrst)
    !cstb_q |=> cstb_q);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (lrst)
    ((st_q == X_DATA) && srdy_n_i) |=> ((st_q == X_DATA) && $stable(bus_q) && oe_q));
  // R9
  hdr_only_chk: assert property (@(posedge clk) disable iff (lrst)
    ((st_q == X_CMD) && (rem_q == '0)) |=> (!oe_q && !hdat_take));
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (lrst)
    (pend_q && !rsp_ready) |=> (pend_q && $stable(rhdr_q) && srdy_q));
  // R8
  slave_only_chk: assert property (@(posedge clk) disable iff (lrst)
    !srdy_q |-> own_br);
endmodule

// File: rtl/bridge_link_ctrl.sv
module bridge_link_ctrl
  import blink_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pgood,
  input  logic          mreq_n_i,
  output logic          mgnt_n_o,
  input  logic          cstb_n_i,
  output logic          cstb_n_o,
  input  logic          srdy_n_i,
  output logic          srdy_n_o,
  input  logic [DW-1:0] lbus_i,
  output logic [DW-1:0] lbus_o,
  output logic          lbus_oe,
  input  logic          hreq_valid,
  output logic          hreq_ready,
  input  logic [DW-1:0] hreq_hdr,
  input  logic [LW-1:0] hreq_len,
  input  logic [DW-1:0] hdat_data,
  output logic          hdat_take,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_hdr,
  output logic [1:0]    strap_o
);
  logic lrst;
  logic x_idle;
  own_t own, own_nxt;
  logic start;

  assign lrst = rst || !pgood;

  blink_strap #(.SW(2)) u_strap (
    .clk   (clk),
    .rst   (rst),
    .pgood (pgood),
    .pins  ({cstb_n_i, srdy_n_i}),
    .strap (strap_o)
  );

  blink_arb u_arb (
    .clk       (clk),
    .lrst      (lrst),
    .mreq_n_i  (mreq_n_i),
    .srdy_n_i  (srdy_n_i),
    .xfer_idle (x_idle && (own == O_CTRL)),
    .own       (own),
    .own_nxt   (own_nxt),
    .mgnt_n_o  (mgnt_n_o)
  );

  assign hreq_ready = !lrst && (own == O_CTRL) && x_idle && !srdy_n_i && mreq_n_i;
  assign start      = hreq_valid && hreq_ready;

  blink_xfer #(.DW(DW), .LW(LW)) u_xfer (
    .clk        (clk),
    .lrst       (lrst),
    .start      (start),
    .hdr        (hreq_hdr),
    .len        (hreq_len),
    .hdat_data  (hdat_data),
    .srdy_n_i   (srdy_n_i),
    .own_br     (own == O_BR),
    .own_br_nxt (own_nxt == O_BR),
    .cstb_n_i   (cstb_n_i),
    .lbus_i     (lbus_i),
    .rsp_ready  (rsp_ready),
    .idle       (x_idle),
    .lbus_o     (lbus_o),
    .lbus_oe    (lbus_oe),
    .cstb_n_o   (cstb_n_o),
    .hdat_take  (hdat_take),
    .srdy_n_o   (srdy_n_o),
    .rsp_valid  (rsp_valid),
    .rsp_hdr    (rsp_hdr)
  );

  // R5
  ready_own_chk: assert property (@(posedge clk) disable iff (lrst)
    hreq_ready |-> (mgnt_n_o && !lbus_oe && cstb_n_o));
  // R7
  bus_release_chk: assert property (@(posedge clk) disable iff (lrst)
    !mgnt_n_o |-> !lbus_oe);
  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (lrst)
    $rose(mgnt_n_o) |-> !hreq_ready);
  // R8
  ready_to_granted_chk: assert property (@(posedge clk) disable iff (lrst)
    !srdy_n_o |-> !mgnt_n_o);
endmodule

// File: tb/bridge_link_ctrl_bench.sv
module bridge_link_ctrl_bench;
  localparam int DW = 16;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst, pgood, mreq_n_i, cstb_n_i, srdy_n_i, hreq_valid, rsp_ready;
  logic [DW-1:0] lbus_i, hreq_hdr, hdat_data;
  logic [LW-1:0] hreq_len;
  logic mgnt_n_o, cstb_n_o, srdy_n_o, lbus_oe, hreq_ready, hdat_take, rsp_valid;
  logic [DW-1:0] lbus_o, rsp_hdr;
  logic [1:0] strap_o;

  always #10 clk = ~clk;

  bridge_link_ctrl #(.DW(DW), .LW(LW)) u_bridge_link_ctrl (
    .clk(clk), .rst(rst), .pgood(pgood), .mreq_n_i(mreq_n_i), .mgnt_n_o(mgnt_n_o),
    .cstb_n_i(cstb_n_i), .cstb_n_o(cstb_n_o), .srdy_n_i(srdy_n_i), .srdy_n_o(srdy_n_o),
    .lbus_i(lbus_i), .lbus_o(lbus_o), .lbus_oe(lbus_oe), .hreq_valid(hreq_valid),
    .hreq_ready(hreq_ready), .hreq_hdr(hreq_hdr), .hreq_len(hreq_len),
    .hdat_data(hdat_data), .hdat_take(hdat_take), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hdr(rsp_hdr), .strap_o(strap_o)
  );

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] hw [0:63];
  int idx = 0;
  int widx = 0;
  logic [DW:0] expq [$];
  bit model_on = 0, stall_en = 0, br_mode = 0, take_pend = 0, prev_stall = 0;
  logic [DW-1:0] prev_bus = '0;
  int cyc = 0;
  int wd = 0;

  assign hdat_data = hw[idx[5:0]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bridge model and scoreboard monitor
  always @(negedge clk) begin
    if (take_pend) idx++;
    take_pend = 0;
    cyc++;
    if (model_on) srdy_n_i = br_mode ? 1'b1 : (stall_en && (cyc % 3 == 1));
    #2;
    if (model_on && pgood && !rst) begin
      take_pend = hdat_take;
      if (prev_stall && lbus_oe) chk(lbus_o == prev_bus, "R4 stall hold", lbus_o, prev_bus);
      if (lbus_oe && !cstb_n_o) begin
        if (expq.size() == 0) chk(0, "R5 unexpected header", lbus_o, 0);
        else begin
          logic [DW:0] e;
          e = expq.pop_front();
          chk(e[DW] == 1'b1 && e[DW-1:0] == lbus_o, "R3 header beat", {1'b1, lbus_o}, e);
        end
      end else if (lbus_oe && !srdy_n_i) begin
        if (expq.size() == 0) chk(0, "R4 unexpected data", lbus_o, 0);
        else begin
          logic [DW:0] e;
          e = expq.pop_front();
          chk(e[DW] == 1'b0 && e[DW-1:0] == lbus_o, "R4 data beat", {1'b0, lbus_o}, e);
        end
      end
      if (!mgnt_n_o && expq.size() != 0) chk(0, "R6 grant during transfer", mgnt_n_o, 1);
      prev_stall = lbus_oe && cstb_n_o && srdy_n_i;
      prev_bus   = lbus_o;
    end
  end

  // driver: push expected beats, then post the request and wait for drain
  task automatic send(input logic [DW-1:0] hdr, input int len);
    expq.push_back({1'b1, hdr});
    for (int k = 0; k < len; k++) expq.push_back({1'b0, hw[widx + k]});
    widx += len;
    @(negedge clk);
    hreq_hdr = hdr;
    hreq_len = LW'(len);
    hreq_valid = 1'b1;
    #3;
    while (!hreq_ready) begin
      @(negedge clk);
      #3;
    end
    @(negedge clk);
    hreq_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", wd);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) hw[i] = 16'h1000 + 16'(i * 16'h0111);
    rst = 1; pgood = 0; mreq_n_i = 1; cstb_n_i = 1; srdy_n_i = 0;
    lbus_i = '0; hreq_valid = 0; hreq_hdr = '0; hreq_len = '0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    #2;
    // R1 link held while power-good is low
    chk(cstb_n_o == 1, "R1 cstb reset", cstb_n_o, 1);
    chk(mgnt_n_o == 1, "R1 grant reset", mgnt_n_o, 1);
    chk(srdy_n_o == 1, "R1 ready reset", srdy_n_o, 1);
    chk(lbus_oe == 0 && hreq_ready == 0 && hdat_take == 0 && rsp_valid == 0,
        "R1 idle outputs", {lbus_oe, hreq_ready, hdat_take, rsp_valid}, 0);
    chk(strap_o == 2'b00, "R2 strap cleared", strap_o, 0);
    @(negedge clk);
    pgood = 1;
    @(negedge clk);
    #2;
    chk(strap_o == 2'b10, "R2 strap latched", strap_o, 2'b10);
    srdy_n_i = 1;
    repeat (2) @(negedge clk);
    #2;
    chk(strap_o == 2'b10, "R2 strap held", strap_o, 2'b10);
    model_on = 1;

    send(16'hA5C3, 3);
    stall_en = 1;
    send(16'h5A01, 4);
    send(16'h0F00, 0); // R9 header only
    stall_en = 0;
    repeat (2) @(negedge clk);

    // R6 / R8 grant and slave capture
    mreq_n_i = 0;
    @(negedge clk);
    #3;
    chk(mgnt_n_o == 0, "R6 grant asserted", mgnt_n_o, 0);
    chk(srdy_n_o == 0, "R8 slave ready", srdy_n_o, 0);
    chk(lbus_oe == 0, "R7 bus released", lbus_oe, 0);
    br_mode = 1;
    @(negedge clk);
    cstb_n_i = 0; lbus_i = 16'hBEEF; hreq_hdr = 16'hDEAD; hreq_len = 2; hreq_valid = 1;
    @(negedge clk);
    cstb_n_i = 1;
    #3;
    chk(rsp_valid == 1 && rsp_hdr == 16'hBEEF, "R8 header captured", rsp_hdr, 16'hBEEF);
    chk(srdy_n_o == 1, "R8 busy while pending", srdy_n_o, 1);
    chk(hreq_ready == 0, "R5 blocked while granted", hreq_ready, 0);
    @(negedge clk);
    #3;
    chk(rsp_valid == 1 && rsp_hdr == 16'hBEEF, "R8 response held", rsp_hdr, 16'hBEEF);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0; hreq_valid = 0; mreq_n_i = 1;
    #3;
    chk(rsp_valid == 0 && srdy_n_o == 0, "R8 response consumed", {rsp_valid, srdy_n_o}, 0);
    chk(mgnt_n_o == 0, "R6 grant held", mgnt_n_o, 0);
    br_mode = 0;
    @(negedge clk);
    #3;
    chk(mgnt_n_o == 1, "R6 grant released", mgnt_n_o, 1);
    chk(hreq_ready == 0, "R7 turnaround", hreq_ready, 0);
    @(negedge clk);
    #3;
    chk(hreq_ready == 1, "R7 control regained", hreq_ready, 1);

    // R6 request during a transfer is deferred
    stall_en = 1;
    fork
      send(16'h7777, 5);
      begin
        repeat (4) @(negedge clk);
        mreq_n_i = 0;
      end
    join
    begin
      bit got;
      got = 0;
      for (int i = 0; i < 4 && !got; i++) begin
        @(negedge clk);
        #3;
        if (!mgnt_n_o) got = 1;
      end
      chk(got, "R6 grant after transfer", mgnt_n_o, 0);
    end
    mreq_n_i = 1;
    stall_en = 0;
    repeat (3) @(negedge clk);
    send(16'h1234, 2);
    chk(expq.size() == 0, "R4 all beats seen", expq.size(), 0);
    summary();
  end
endmodule